// File: doc/BRIEF.md
# SDRAM Command Input Qualifier

This block sits at the input edge of a synchronous DRAM device model. On every rising clock edge it captures the chip select, clock enable, the three command strobes (row, column, write), the bank select and the address bus. It turns them into a registered set of single-cycle command pulses, each with its bank, row or column and its precharge qualifiers attached. Downstream array, refresh and mode logic can then act on clean one-hot events and need not decode raw pins.

The block keeps one open-row flag per bank. Activate sets the flag. A manual precharge clears it, and so does a read or write that carries the auto-precharge request. A read or write aimed at a bank with no open row is refused and reported. The column field is cut to the width of the selected organisation: nine bits for the byte-wide part, eight bits for the word-wide part. While clock enable is low, no command is taken. The block then reports whether the device would be in power-down (every bank idle) or in clock suspend (some row still open).

Top module: `sdram_cmd_qualifier`

## Requirements
- R1: Inputs are sampled on the rising clock edge. Every output is registered and changes only just after an edge, reflecting the inputs sampled at that edge.
- R2: A command is accepted when clock enable is high and chip select is low. The strobe levels {row, column, write} decode as follows: 011 = activate, 101 = read, 100 = write, 010 = precharge, 001 = refresh, 000 = mode load, 111 = no operation. Each accepted command raises its pulse output for exactly one cycle.
- R3: When chip select is high or clock enable is low, no command pulse is raised and the open-row flags keep their values.
- R4: At most one of the pulses act, rd, wr, pre, ref, mrs and emrs is high in any cycle.
- R5: A mode load with bank bit 0 low raises `mrs_o`, and with bank bit 0 high raises `emrs_o`. In both cases `row_o` carries the address bus.
- R6: On precharge, address bit 10 low clears only the open flag of the selected bank. Address bit 10 high clears all four flags and raises `pre_all_o`.
- R7: A read or write to an open bank with address bit 10 high raises `auto_pre_o`, and the bank's open flag is clear after that edge.
- R8: Activate sets the open flag of the selected bank and puts the full 12-bit address on `row_o`.
- R9: On an accepted read or write, `col_o` is address bits 8..0 when `x16_i` is low. When `x16_i` is high it is address bits 7..0 with bit 8 forced to zero.
- R10: A read or write to a bank whose flag is clear raises `err_o` instead of `rd_o`/`wr_o`, and it leaves every open flag unchanged.
- R11: At an edge with clock enable low, `pwr_dn_o` is raised if all flags are clear and `susp_o` is raised otherwise. Both are low when clock enable is high.
- R12: After reset, every pulse and field output is zero and every bank is idle.
- R13: `bank_o` carries the bank select on activate, read, write, precharge and error cycles and is zero otherwise. `row_o` is zero except on activate and mode loads. `col_o` and `auto_pre_o` are zero except on read or write. `pre_all_o` is zero except on precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes command intake |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address bus; bit 10 is the precharge qualifier |
| x16_i | input | 1 | High selects the word-wide organisation |
| act_o | output | 1 | Activate pulse |
| rd_o | output | 1 | Read pulse |
| wr_o | output | 1 | Write pulse |
| pre_o | output | 1 | Precharge pulse |
| ref_o | output | 1 | Refresh pulse |
| mrs_o | output | 1 | Normal mode load pulse |
| emrs_o | output | 1 | Extended mode load pulse |
| err_o | output | 1 | Access to a bank with no open row |
| pre_all_o | output | 1 | Precharge covers every bank |
| auto_pre_o | output | 1 | Access requests auto-precharge |
| pwr_dn_o | output | 1 | Clock held off with all banks idle |
| susp_o | output | 1 | Clock held off with a row open |
| bank_o | output | 2 | Bank of the current event |
| row_o | output | 12 | Row address or mode value |
| col_o | output | 9 | Column address |
| bank_open_o | output | 4 | Open-row flag per bank |

## Verification
The assertions assume a synchronous reset release and inputs that are stable around the rising edge. They do not assume that the controller obeys bank protocol: reads to closed banks, activates on open banks and commands under a held clock enable are all legal stimulus. The bench drives every input at the falling edge, so each capture sees settled values. It mixes directed sequences with a long weighted-random run that covers all eight strobe codes, deselected cycles, clock-enable dropouts and both organisations. This lets every flag transition and error path occur many times.

// File: rtl/sdcq_pkg.sv
package sdcq_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MODE
    } cmd_e;

    // strobe levels {ras_n, cas_n, we_n}
    localparam logic [2:0] ENC_ACT  = 3'b011;
    localparam logic [2:0] ENC_RD   = 3'b101;
    localparam logic [2:0] ENC_WR   = 3'b100;
    localparam logic [2:0] ENC_PRE  = 3'b010;
    localparam logic [2:0] ENC_REF  = 3'b001;
    localparam logic [2:0] ENC_MODE = 3'b000;

endpackage

// File: rtl/sdcq_cmd_decode.sv
module sdcq_cmd_decode
    import sdcq_pkg::*;
(
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    logic       take;
    logic [2:0] code;

    always_comb begin
        take  = cke_i & ~cs_n_i;
        code  = {ras_n_i, cas_n_i, we_n_i};
        cmd_o = CMD_NONE;
        if (take) begin
            unique case (code)
                ENC_ACT:  cmd_o = CMD_ACT;
                ENC_RD:   cmd_o = CMD_RD;
                ENC_WR:   cmd_o = CMD_WR;
                ENC_PRE:  cmd_o = CMD_PRE;
                ENC_REF:  cmd_o = CMD_REF;
                ENC_MODE: cmd_o = CMD_MODE;
                default:  cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdcq_addr_split.sv
module sdcq_addr_split #(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int COL_NARROW_W = 8,
    parameter int AP_BIT       = 10
) (
    input  logic [ROW_W-1:0] addr_i,
    input  logic             x16_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             ap_o
);

    logic [COL_W-1:0] col_wide;
    logic [COL_W-1:0] col_narrow;

    always_comb begin
        row_o      = addr_i;
        ap_o       = addr_i[AP_BIT];
        col_wide   = addr_i[COL_W-1:0];
        col_narrow = '0;
        col_narrow[COL_NARROW_W-1:0] = addr_i[COL_NARROW_W-1:0];
        col_o      = x16_i ? col_narrow : col_wide;
    end

endmodule

// File: rtl/sdcq_bank_track.sv
module sdcq_bank_track #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_one_i,
    input  logic              clr_all_i,
    input  logic [BANK_W-1:0] sel_i,
    output logic [NBANK-1:0]  open_o
);

    logic [NBANK-1:0] open_d;
    logic [NBANK-1:0] open_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        always_comb begin
            hit       = (sel_i == BANK_W'(b));
            open_d[b] = open_q[b];
            if (clr_all_i) begin
                open_d[b] = 1'b0;
            end else if (hit && set_i) begin
                open_d[b] = 1'b1;
            end else if (hit && clr_one_i) begin
                open_d[b] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) open_q[b] <= 1'b0;
            else        open_q[b] <= open_d[b];
        end
    end

    assign open_o = open_q;

endmodule

// File: rtl/sdram_cmd_qualifier.sv
module sdram_cmd_qualifier
    import sdcq_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int COL_NARROW_W = 8,
    parameter int BANK_W       = 2,
    parameter int AP_BIT       = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_i,
    input  logic                     cs_n_i,
    input  logic                     ras_n_i,
    input  logic                     cas_n_i,
    input  logic                     we_n_i,
    input  logic [BANK_W-1:0]        ba_i,
    input  logic [ROW_W-1:0]         addr_i,
    input  logic                     x16_i,
    output logic                     act_o,
    output logic                     rd_o,
    output logic                     wr_o,
    output logic                     pre_o,
    output logic                     ref_o,
    output logic                     mrs_o,
    output logic                     emrs_o,
    output logic                     err_o,
    output logic                     pre_all_o,
    output logic                     auto_pre_o,
    output logic                     pwr_dn_o,
    output logic                     susp_o,
    output logic [BANK_W-1:0]        bank_o,
    output logic [ROW_W-1:0]         row_o,
    output logic [COL_W-1:0]         col_o,
    output logic [(1<<BANK_W)-1:0]   bank_open_o
);

    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              wr;
        logic              pre;
        logic              refr;
        logic              mrs;
        logic              emrs;
        logic              err;
        logic              pre_all;
        logic              auto_pre;
        logic              pwr_dn;
        logic              susp;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } evt_t;

    evt_t st_d;
    evt_t st_q;

    cmd_e             cmd;
    logic [ROW_W-1:0] row_w;
    logic [COL_W-1:0] col_w;
    logic             ap_w;
    logic [NBANK-1:0] open_w;
    logic             bank_hit;
    logic             trk_set;
    logic             trk_clr_one;
    logic             trk_clr_all;

    sdcq_cmd_decode u_dec (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (cmd)
    );

    sdcq_addr_split #(
        .ROW_W        (ROW_W),
        .COL_W        (COL_W),
        .COL_NARROW_W (COL_NARROW_W),
        .AP_BIT       (AP_BIT)
    ) u_split (
        .addr_i (addr_i),
        .x16_i  (x16_i),
        .row_o  (row_w),
        .col_o  (col_w),
        .ap_o   (ap_w)
    );

    sdcq_bank_track #(
        .BANK_W (BANK_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (trk_set),
        .clr_one_i (trk_clr_one),
        .clr_all_i (trk_clr_all),
        .sel_i     (ba_i),
        .open_o    (open_w)
    );

    // next-state: event fields and bank flag control
    always_comb begin
        st_d        = '0;
        bank_hit    = open_w[ba_i];
        trk_set     = 1'b0;
        trk_clr_one = 1'b0;
        trk_clr_all = 1'b0;

        unique case (cmd)
            CMD_ACT: begin
                st_d.act  = 1'b1;
                st_d.bank = ba_i;
                st_d.row  = row_w;
                trk_set   = 1'b1;
            end
            CMD_RD, CMD_WR: begin
                st_d.bank = ba_i;
                if (bank_hit) begin
                    st_d.rd       = (cmd == CMD_RD);
                    st_d.wr       = (cmd == CMD_WR);
                    st_d.col      = col_w;
                    st_d.auto_pre = ap_w;
                    trk_clr_one   = ap_w;
                end else begin
                    st_d.err = 1'b1;
                end
            end
            CMD_PRE: begin
                st_d.pre     = 1'b1;
                st_d.bank    = ba_i;
                st_d.pre_all = ap_w;
                trk_clr_all  = ap_w;
                trk_clr_one  = ~ap_w;
            end
            CMD_REF: begin
                st_d.refr = 1'b1;
            end
            CMD_MODE: begin
                st_d.mrs  = ~ba_i[0];
                st_d.emrs = ba_i[0];
                st_d.row  = row_w;
            end
            default: begin
                st_d = '0;
            end
        endcase

        if (!cke_i) begin
            st_d.pwr_dn = ~|open_w;
            st_d.susp   = |open_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o       = st_q.act;
    assign rd_o        = st_q.rd;
    assign wr_o        = st_q.wr;
    assign pre_o       = st_q.pre;
    assign ref_o       = st_q.refr;
    assign mrs_o       = st_q.mrs;
    assign emrs_o      = st_q.emrs;
    assign err_o       = st_q.err;
    assign pre_all_o   = st_q.pre_all;
    assign auto_pre_o  = st_q.auto_pre;
    assign pwr_dn_o    = st_q.pwr_dn;
    assign susp_o      = st_q.susp;
    assign bank_o      = st_q.bank;
    assign row_o       = st_q.row;
    assign col_o       = st_q.col;
    assign bank_open_o = open_w;

endmodule

// File: rtl/sdcq_checker.sv
module sdcq_checker #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke_i,
    input logic                   cs_n_i,
    input logic                   act_o,
    input logic                   rd_o,
    input logic                   wr_o,
    input logic                   pre_o,
    input logic                   ref_o,
    input logic                   mrs_o,
    input logic                   emrs_o,
    input logic                   err_o,
    input logic                   pre_all_o,
    input logic                   auto_pre_o,
    input logic                   pwr_dn_o,
    input logic                   susp_o,
    input logic [BANK_W-1:0]      bank_o,
    input logic [ROW_W-1:0]       row_o,
    input logic [COL_W-1:0]       col_o,
    input logic [(1<<BANK_W)-1:0] bank_open_o
);

    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    logic [6:0] pulses;
    assign pulses = {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, emrs_o};

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses)); // R4

    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(cs_n_i) || !$past(cke_i)) |-> (pulses == '0 && !err_o)); // R3

    AST_GATED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(cs_n_i) || !$past(cke_i)) |-> $stable(bank_open_o)); // R3

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> bank_open_o[bank_o]); // R8

    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_o && pre_all_o) |-> (bank_open_o == '0)); // R6

    AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> !bank_open_o[bank_o]); // R7

    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!rd_o && !wr_o && !bank_open_o[bank_o])); // R10

    AST_LOWPWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_dn_o && susp_o)); // R11

    AST_PWRDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_o |-> (bank_open_o == '0)); // R11

    AST_COL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o || wr_o) |-> (col_o == '0 && !auto_pre_o)); // R13

    AST_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_o || mrs_o || emrs_o) |-> (row_o == '0)); // R13

endmodule

bind sdram_cmd_qualifier sdcq_checker #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W)
) u_sdcq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_i       (cke_i),
    .cs_n_i      (cs_n_i),
    .act_o       (act_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .pre_o       (pre_o),
    .ref_o       (ref_o),
    .mrs_o       (mrs_o),
    .emrs_o      (emrs_o),
    .err_o       (err_o),
    .pre_all_o   (pre_all_o),
    .auto_pre_o  (auto_pre_o),
    .pwr_dn_o    (pwr_dn_o),
    .susp_o      (susp_o),
    .bank_o      (bank_o),
    .row_o       (row_o),
    .col_o       (col_o),
    .bank_open_o (bank_open_o)
);

// File: tb/tb_sdram_cmd_qualifier.sv
`timescale 1ns/1ps
module tb_sdram_cmd_qualifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_i = 1'b1;
    logic        cs_n_i = 1'b1;
    logic        ras_n_i = 1'b1;
    logic        cas_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic [1:0]  ba_i = '0;
    logic [11:0] addr_i = '0;
    logic        x16_i = 1'b0;

    logic        act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, emrs_o, err_o;
    logic        pre_all_o, auto_pre_o, pwr_dn_o, susp_o;
    logic [1:0]  bank_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic [3:0]  bank_open_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sdram_cmd_qualifier dut (
        .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .addr_i(addr_i), .x16_i(x16_i),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
        .ref_o(ref_o), .mrs_o(mrs_o), .emrs_o(emrs_o), .err_o(err_o),
        .pre_all_o(pre_all_o), .auto_pre_o(auto_pre_o),
        .pwr_dn_o(pwr_dn_o), .susp_o(susp_o), .bank_o(bank_o),
        .row_o(row_o), .col_o(col_o), .bank_open_o(bank_open_o)
    );

    // behavioural reference
    bit         m_open [4];
    logic [6:0] e_pulse;      // {act, rd, wr, pre, ref, mrs, emrs}
    logic       e_err, e_pall, e_ap, e_pd, e_sus;
    logic [1:0] e_bank;
    logic [11:0] e_row;
    logic [8:0] e_col;

    function automatic logic [3:0] flags();
        return {m_open[3], m_open[2], m_open[1], m_open[0]};
    endfunction

    always @(posedge clk) begin
        e_pulse = '0; e_err = 0; e_pall = 0; e_ap = 0; e_pd = 0; e_sus = 0;
        e_bank = '0; e_row = '0; e_col = '0;
        if (!rst_n) begin
            foreach (m_open[i]) m_open[i] = 0;
        end else begin
            if (!cke_i) begin
                e_pd  = (flags() == 4'b0);
                e_sus = (flags() != 4'b0);
            end else if (!cs_n_i) begin
                case ({ras_n_i, cas_n_i, we_n_i})
                    3'b011: begin
                        e_pulse[6] = 1; e_bank = ba_i; e_row = addr_i;
                        m_open[ba_i] = 1;
                    end
                    3'b101, 3'b100: begin
                        e_bank = ba_i;
                        if (m_open[ba_i]) begin
                            if (we_n_i) e_pulse[5] = 1; else e_pulse[4] = 1;
                            e_col = x16_i ? {1'b0, addr_i[7:0]} : addr_i[8:0];
                            e_ap  = addr_i[10];
                            if (addr_i[10]) m_open[ba_i] = 0;
                        end else begin
                            e_err = 1;
                        end
                    end
                    3'b010: begin
                        e_pulse[3] = 1; e_bank = ba_i; e_pall = addr_i[10];
                        if (addr_i[10]) foreach (m_open[i]) m_open[i] = 0;
                        else m_open[ba_i] = 0;
                    end
                    3'b001: e_pulse[2] = 1;
                    3'b000: begin
                        if (ba_i[0]) e_pulse[0] = 1; else e_pulse[1] = 1;
                        e_row = addr_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // R1: compared mid-cycle, after the edge that produced them
    task automatic compare();
        logic [6:0] p;
        p = {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, emrs_o};
        chk("R2 pulses", 32'(p), 32'(e_pulse));
        chk("R4 one pulse", 32'($countones(p) <= 1), 32'd1);
        chk("R10 err", 32'(err_o), 32'(e_err));
        chk("R6 flags", 32'(bank_open_o), 32'(flags()));
        chk("R6 pre_all", 32'(pre_all_o), 32'(e_pall));
        chk("R7 auto_pre", 32'(auto_pre_o), 32'(e_ap));
        chk("R8 row", 32'(row_o), 32'(e_row));
        chk("R9 col", 32'(col_o), 32'(e_col));
        chk("R13 bank", 32'(bank_o), 32'(e_bank));
        chk("R11 lowpower", 32'({pwr_dn_o, susp_o}), 32'({e_pd, e_sus}));
    endtask

    task automatic step(input logic cke, input logic cs_n, input logic [2:0] code,
                        input logic [1:0] ba, input logic [11:0] addr, input logic x16);
        cke_i = cke; cs_n_i = cs_n; {ras_n_i, cas_n_i, we_n_i} = code;
        ba_i = ba; addr_i = addr; x16_i = x16;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset outputs", 32'({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, emrs_o,
            err_o, pre_all_o, auto_pre_o, pwr_dn_o, susp_o}), 32'd0);
        chk("R12 reset fields", 32'({bank_o, row_o, col_o}), 32'd0);
        chk("R12 banks idle", 32'(bank_open_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: read on idle bank
        step(1, 0, 3'b101, 2'd1, 12'h012, 0);
        chk("R10 err on closed bank", 32'(err_o), 32'd1);
        // R8: activate bank 2
        step(1, 0, 3'b011, 2'd2, 12'hABC, 0);
        chk("R8 act row", 32'({act_o, row_o}), 32'({1'b1, 12'hABC}));
        // R3: deselected activate on bank 0
        step(1, 1, 3'b011, 2'd0, 12'h111, 0);
        chk("R3 cs high ignored", 32'({act_o, bank_open_o}), 32'({1'b0, 4'b0100}));
        // R11 + R3: clock enable low with a row open
        step(0, 0, 3'b011, 2'd0, 12'h111, 0);
        chk("R11 suspend", 32'({act_o, pwr_dn_o, susp_o, bank_open_o}),
            32'({1'b0, 1'b0, 1'b1, 4'b0100}));
        // R9: word-wide column
        step(1, 0, 3'b101, 2'd2, 12'h3FF, 1);
        chk("R9 x16 column", 32'({rd_o, col_o}), 32'({1'b1, 9'h0FF}));
        // R9: byte-wide column, write
        step(1, 0, 3'b100, 2'd2, 12'h3FF, 0);
        chk("R9 x8 column", 32'({wr_o, col_o}), 32'({1'b1, 9'h1FF}));
        // R7: auto-precharge read
        step(1, 0, 3'b101, 2'd2, 12'h400, 0);
        chk("R7 auto precharge", 32'({rd_o, auto_pre_o, bank_open_o}),
            32'({1'b1, 1'b1, 4'b0000}));
        // R6: single and all-bank precharge
        step(1, 0, 3'b011, 2'd0, 12'h001, 0);
        step(1, 0, 3'b011, 2'd3, 12'h002, 0);
        step(1, 0, 3'b010, 2'd0, 12'h000, 0);
        chk("R6 single precharge", 32'({pre_all_o, bank_open_o}), 32'({1'b0, 4'b1000}));
        step(1, 0, 3'b011, 2'd1, 12'h003, 0);
        step(1, 0, 3'b010, 2'd2, 12'h400, 0);
        chk("R6 all precharge", 32'({pre_o, pre_all_o, bank_open_o}), 32'({2'b11, 4'b0000}));
        // R11: power-down
        step(0, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R11 power down", 32'({pwr_dn_o, susp_o}), 32'b10);
        // R5: mode loads
        step(1, 0, 3'b000, 2'd0, 12'h5A5, 0);
        chk("R5 normal mode", 32'({mrs_o, emrs_o, row_o}), 32'({2'b10, 12'h5A5}));
        step(1, 0, 3'b000, 2'd1, 12'h0C3, 0);
        chk("R5 extended mode", 32'({mrs_o, emrs_o, row_o}), 32'({2'b01, 12'h0C3}));
        // R2: refresh, then no-op gives nothing
        step(1, 0, 3'b001, 2'd3, 12'hFFF, 0);
        chk("R2 refresh", 32'({ref_o, bank_o, row_o}), 32'({1'b1, 14'd0}));
        step(1, 0, 3'b111, 2'd3, 12'hFFF, 0);
        chk("R13 nop fields", 32'({ref_o, bank_o, row_o, col_o}), 32'd0);

        // weighted random traffic
        for (int n = 0; n < 6000; n++) begin
            step(($urandom % 12) != 0, ($urandom % 8) == 0, 3'($urandom),
                 2'($urandom), 12'($urandom), ($urandom % 4) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule